// File: doc/BRIEF.md
# MSI Vector Capture Controller

This block collects message-signalled interrupts arriving from the link side. An inbound write that targets the dedicated MSI doorbell address carries a vector number in the low five bits of its data. The block records that vector as pending in a 32-bit pending register. Software controls which vectors may interrupt through a per-vector enable mask. The mask has a set port and a clear port, and each writes only the bits given as ones.

Software acknowledges a vector by writing the pending register with a zero in that vector's bit and ones everywhere else. Ones leave bits untouched. Software can read the pending register again after each acknowledge until it reads back empty. A single interrupt output, registered, is high while any pending vector is also enabled. Pending bits are recorded whether or not the vector is enabled.

The block has two ports. The inbound MSI port carries link traffic. The software register port is used by the processor. Both can act in the same cycle.

Top module: `msi_vector_capture`

## Requirements
- R1: After reset the pending register and the enable mask are zero, `irq_out` is low and `sw_rdata` is zero.
- R2: An inbound write with `msi_valid` high and `msi_addr` equal to 0x054 sets pending bit `msi_data[4:0]` at that clock edge. `msi_data[31:5]` has no effect.
- R3: An inbound write whose `msi_addr` is not 0x054 leaves the pending register unchanged.
- R4: A software write to the pending register (offset 0x040) clears every pending bit whose written bit is 0. It leaves every bit whose written bit is 1 unchanged.
- R5: A software write to the enable-set register (offset 0x048) sets the mask bits written as 1. Zero bits have no effect.
- R6: A software write to the enable-clear register (offset 0x04C) clears the mask bits written as 1. Zero bits have no effect.
- R7: When `sw_rd_en` is high, `sw_rdata` after the next edge holds the pending register for offset 0x040, and the enable mask for 0x048 or 0x04C. The values are those from before that edge. `sw_rdata` is zero in a cycle that follows no read.
- R8: `irq_out` equals the OR of (pending AND mask) as it stood one clock earlier.
- R9: When an inbound MSI for vector n arrives in the same cycle as a software write that clears bit n, bit n ends set.
- R10: A vector that is pending while disabled keeps `irq_out` low. It raises `irq_out` once it is enabled.
- R11: Software reads of any other offset return zero. Software writes to any other offset, including 0x054, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_rd_en | input | 1 | Software read strobe |
| sw_addr | input | 12 | Software register byte offset |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Registered software read data |
| msi_valid | input | 1 | Inbound write valid |
| msi_addr | input | 12 | Inbound write byte offset |
| msi_data | input | 32 | Inbound write data, vector in bits 4:0 |
| irq_out | output | 1 | Combined interrupt, registered |

## Verification
Pending and mask updates take effect at the edge that samples the write. `sw_rdata` is due one edge after the read request and shows the state from before that edge. `irq_out` reflects the pending and mask state one edge later, so it follows an inbound MSI by two edges. The bench drives each operation after a falling edge and samples one nanosecond after the next rising edge. At that edge it updates a reference model. It compares `irq_out` and `sw_rdata` every cycle against values the model computed from the state before the edge.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
    // Width of the vector field carried in inbound MSI data
    localparam int VEC_FIELD_W = 5;

    // Selection of the software read-back source
    typedef enum logic [1:0] {
        RD_NONE    = 2'd0,
        RD_PENDING = 2'd1,
        RD_MASK    = 2'd2
    } rd_sel_e;
endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
    import msi_cap_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int NUM_VEC = 32,
    parameter int PEND_OFF = 'h040,
    parameter int ESET_OFF = 'h048,
    parameter int ECLR_OFF = 'h04C,
    parameter int DOOR_OFF = 'h054
) (
    input  logic                   sw_wr_en,
    input  logic                   sw_rd_en,
    input  logic [ADDR_W-1:0]      sw_addr,
    input  logic                   msi_valid,
    input  logic [ADDR_W-1:0]      msi_addr,
    input  logic [DATA_W-1:0]      msi_data,
    output logic                   ack_wr,
    output logic                   eset_wr,
    output logic                   eclr_wr,
    output logic                   msi_hit,
    output logic [VEC_FIELD_W-1:0] msi_vec,
    output rd_sel_e                rd_sel
);
    logic hit_pend, hit_eset, hit_eclr, door_match;
    logic unused_msi_hi;

    assign hit_pend   = (sw_addr == ADDR_W'(PEND_OFF));
    assign hit_eset   = (sw_addr == ADDR_W'(ESET_OFF));
    assign hit_eclr   = (sw_addr == ADDR_W'(ECLR_OFF));
    assign door_match = (msi_addr == ADDR_W'(DOOR_OFF));

    assign ack_wr  = sw_wr_en && hit_pend;
    assign eset_wr = sw_wr_en && hit_eset;
    assign eclr_wr = sw_wr_en && hit_eclr;

    // Vector number comes from the low field; higher data bits are dropped
    assign msi_vec = msi_data[VEC_FIELD_W-1:0];
    assign msi_hit = msi_valid && door_match &&
                     ({27'd0, msi_vec} < 32'(NUM_VEC));
    assign unused_msi_hi = ^msi_data[DATA_W-1:VEC_FIELD_W];

    always_comb begin
        rd_sel = RD_NONE;
        if (sw_rd_en) begin
            if (hit_pend)                  rd_sel = RD_PENDING;
            else if (hit_eset || hit_eclr) rd_sel = RD_MASK;
        end
    end
endmodule

// File: rtl/msi_pending_bank.sv
module msi_pending_bank
    import msi_cap_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   msi_hit,
    input  logic [VEC_FIELD_W-1:0] msi_vec,
    input  logic                   ack_wr,
    input  logic [NUM_VEC-1:0]     ack_data,
    output logic [NUM_VEC-1:0]     pend_o
);
    typedef struct packed {
        logic [NUM_VEC-1:0] pend;
    } pend_state_t;

    pend_state_t st_d, st_q;
    logic [NUM_VEC-1:0] set_vec;
    logic [NUM_VEC-1:0] keep_vec;

    // One-hot decode of the arriving vector, one comparator per bit
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
        assign set_vec[g]  = msi_hit && (msi_vec == VEC_FIELD_W'(g));
        assign keep_vec[g] = !ack_wr || ack_data[g];
    end

    always_comb begin
        st_d = st_q;
        // Arrival takes priority over a same-cycle acknowledge
        st_d.pend = (st_q.pend & keep_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    assert_msi_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_hit && !ack_wr) |=> ((pend_o & $past(set_vec)) == $past(set_vec)));

    assert_msi_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_hit && ack_wr) |=> ((pend_o & $past(set_vec)) == $past(set_vec)));

    assert_ack_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> (($past(pend_o) & $past(ack_data) & ~pend_o) == '0));

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !msi_hit) |=> ((pend_o & ~$past(ack_data)) == '0));

    assert_single_arrival_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_vec));
endmodule

// File: rtl/msi_enable_mask.sv
module msi_enable_mask #(
    parameter int NUM_VEC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               eset_wr,
    input  logic               eclr_wr,
    input  logic [NUM_VEC-1:0] wdata,
    output logic [NUM_VEC-1:0] mask_o
);
    typedef struct packed {
        logic [NUM_VEC-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (eset_wr) st_d.mask = st_d.mask | wdata;
        if (eclr_wr) st_d.mask = st_d.mask & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;

    assert_eset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eset_wr |=> ((($past(wdata) & ~mask_o) == '0) &&
                     (($past(mask_o) & ~mask_o) == '0)));

    assert_eclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eclr_wr |=> ((($past(wdata) & mask_o) == '0) &&
                     ((mask_o & ~$past(mask_o)) == '0)));

    assert_mask_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!eset_wr && !eclr_wr) |=> $stable(mask_o));
endmodule

// File: rtl/msi_irq_combine.sv
module msi_irq_combine #(
    parameter int NUM_VEC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] pend_i,
    input  logic [NUM_VEC-1:0] mask_i,
    output logic               irq_o
);
    typedef struct packed {
        logic irq;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(pend_i & mask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |=> !irq_o);

    assert_nothing_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |=> !irq_o);

    assert_enabled_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & mask_i) != '0) |=> irq_o);
endmodule

// File: rtl/msi_vector_capture.sv
module msi_vector_capture
    import msi_cap_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int NUM_VEC  = 32,
    parameter int PEND_OFF = 'h040,
    parameter int ESET_OFF = 'h048,
    parameter int ECLR_OFF = 'h04C,
    parameter int DOOR_OFF = 'h054
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr_en,
    input  logic              sw_rd_en,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic [DATA_W-1:0] sw_wdata,
    output logic [DATA_W-1:0] sw_rdata,
    input  logic              msi_valid,
    input  logic [ADDR_W-1:0] msi_addr,
    input  logic [DATA_W-1:0] msi_data,
    output logic              irq_out
);
    localparam int PAD_W = DATA_W - NUM_VEC;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    logic                   ack_wr, eset_wr, eclr_wr, msi_hit;
    logic [VEC_FIELD_W-1:0] msi_vec;
    rd_sel_e                rd_sel;
    logic [NUM_VEC-1:0]     pend, mask;

    msi_reg_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_VEC(NUM_VEC),
        .PEND_OFF(PEND_OFF), .ESET_OFF(ESET_OFF),
        .ECLR_OFF(ECLR_OFF), .DOOR_OFF(DOOR_OFF)
    ) u_decode (
        .sw_wr_en (sw_wr_en),
        .sw_rd_en (sw_rd_en),
        .sw_addr  (sw_addr),
        .msi_valid(msi_valid),
        .msi_addr (msi_addr),
        .msi_data (msi_data),
        .ack_wr   (ack_wr),
        .eset_wr  (eset_wr),
        .eclr_wr  (eclr_wr),
        .msi_hit  (msi_hit),
        .msi_vec  (msi_vec),
        .rd_sel   (rd_sel)
    );

    msi_pending_bank #(.NUM_VEC(NUM_VEC)) u_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .msi_hit (msi_hit),
        .msi_vec (msi_vec),
        .ack_wr  (ack_wr),
        .ack_data(sw_wdata[NUM_VEC-1:0]),
        .pend_o  (pend)
    );

    msi_enable_mask #(.NUM_VEC(NUM_VEC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .eset_wr(eset_wr),
        .eclr_wr(eclr_wr),
        .wdata  (sw_wdata[NUM_VEC-1:0]),
        .mask_o (mask)
    );

    msi_irq_combine #(.NUM_VEC(NUM_VEC)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .pend_i(pend),
        .mask_i(mask),
        .irq_o (irq_out)
    );

    always_comb begin
        st_d = st_q;
        unique case (rd_sel)
            RD_PENDING: st_d.rdata = {{PAD_W{1'b0}}, pend};
            RD_MASK:    st_d.rdata = {{PAD_W{1'b0}}, mask};
            default:    st_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sw_rdata = st_q.rdata;

    assert_idle_rdata_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_rd_en |=> (sw_rdata == '0));

    assert_door_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!msi_hit && !ack_wr) |=> $stable(pend));
endmodule

// File: tb/msi_vector_capture_bench.sv
module msi_vector_capture_bench;
    localparam logic [11:0] A_PEND = 12'h040;
    localparam logic [11:0] A_ESET = 12'h048;
    localparam logic [11:0] A_ECLR = 12'h04C;
    localparam logic [11:0] A_DOOR = 12'h054;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr_en = 1'b0, sw_rd_en = 1'b0;
    logic [11:0] sw_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        msi_valid = 1'b0;
    logic [11:0] msi_addr = '0;
    logic [31:0] msi_data = '0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_pend = '0, m_mask = '0;

    always #2 clk = ~clk;

    msi_vector_capture u_msi_vector_capture (
        .clk(clk), .rst_n(rst_n),
        .sw_wr_en(sw_wr_en), .sw_rd_en(sw_rd_en), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .msi_valid(msi_valid), .msi_addr(msi_addr), .msi_data(msi_data),
        .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [11:0] a);
        if (a == A_PEND) return m_pend;
        if (a == A_ESET || a == A_ECLR) return m_mask;
        return 32'h0;
    endfunction

    // One cycle: drive after a falling edge, model at the rising edge, sample 1 ns later
    task automatic tick(input bit wr, input bit rd, input logic [11:0] a,
                        input logic [31:0] wd, input bit mv,
                        input logic [11:0] ma, input logic [31:0] md,
                        input string tag);
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [31:0] setb;
        @(negedge clk);
        sw_wr_en = wr; sw_rd_en = rd; sw_addr = a; sw_wdata = wd;
        msi_valid = mv; msi_addr = ma; msi_data = md;
        @(posedge clk);
        exp_irq = |(m_pend & m_mask);
        exp_rd  = rd ? model_read(a) : 32'h0;
        setb    = (mv && ma == A_DOOR) ? (32'h1 << md[4:0]) : 32'h0;
        m_pend  = (m_pend & ((wr && a == A_PEND) ? wd : 32'hFFFF_FFFF)) | setb;
        if (wr && a == A_ESET) m_mask = m_mask | wd;
        if (wr && a == A_ECLR) m_mask = m_mask & ~wd;
        #1;
        chk({tag, " R8 irq"}, {31'd0, irq_out}, {31'd0, exp_irq});
        chk({tag, " R7 rdata"}, sw_rdata, exp_rd);
    endtask

    task automatic idle(input string tag);
        tick(0, 0, 12'h0, 32'h0, 0, 12'h0, 32'h0, tag);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        tick(0, 1, a, 32'h0, 0, 12'h0, 32'h0, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        tick(1, 0, a, d, 0, 12'h0, 32'h0, tag);
    endtask

    task automatic msi(input logic [11:0] a, input logic [31:0] d, input string tag);
        tick(0, 0, 12'h0, 32'h0, 1, a, d, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 irq in reset", {31'd0, irq_out}, 32'h0);
        chk("R1 rdata in reset", sw_rdata, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset contents
        rd(A_PEND, "R1 pend"); chk("R1 pending zero", sw_rdata, 32'h0);
        rd(A_ESET, "R1 mask"); chk("R1 mask zero", sw_rdata, 32'h0);

        // R2: vector from low five bits, upper bits ignored; R10: disabled stays quiet
        msi(A_DOOR, 32'hFFFF_FFE5, "R2 msi");
        idle("R10 idle");
        chk("R10 disabled pending no irq", {31'd0, irq_out}, 32'h0);
        rd(A_PEND, "R2 read"); chk("R2 pending bit5", sw_rdata, 32'h0000_0020);

        // R3: wrong inbound address ignored
        msi(12'h050, 32'h7, "R3 msi");
        rd(A_PEND, "R3 read"); chk("R3 pending unchanged", sw_rdata, 32'h0000_0020);

        // R5 / R7: enable-set, read back through both mask offsets
        wr(A_ESET, 32'h0000_0021, "R5 set");
        rd(A_ECLR, "R7 read clr"); chk("R7 mask via clear offset", sw_rdata, 32'h0000_0021);
        chk("R10 irq after enable", {31'd0, irq_out}, 32'h1);
        wr(A_ESET, 32'h0, "R5 zero");
        rd(A_ESET, "R5 read"); chk("R5 zero write no effect", sw_rdata, 32'h0000_0021);

        // R6: enable-clear
        wr(A_ECLR, 32'h0000_0001, "R6 clr");
        wr(A_ECLR, 32'h0, "R6 zero");
        rd(A_ESET, "R6 read"); chk("R6 mask after clear", sw_rdata, 32'h0000_0020);

        // R4: ones keep, zero clears
        wr(A_PEND, 32'hFFFF_FFFF, "R4 ones");
        rd(A_PEND, "R4 read1"); chk("R4 ones keep pending", sw_rdata, 32'h0000_0020);
        wr(A_PEND, ~32'h0000_0020, "R4 ack");
        rd(A_PEND, "R4 read2"); chk("R4 ack clears bit5", sw_rdata, 32'h0);
        chk("R8 irq dropped", {31'd0, irq_out}, 32'h0);

        // R9: arrival beats same-cycle acknowledge
        tick(1, 0, A_PEND, ~32'h0000_0200, 1, A_DOOR, 32'h9, "R9 collide");
        rd(A_PEND, "R9 read"); chk("R9 msi wins", sw_rdata, 32'h0000_0200);

        // R11: unmapped offsets
        wr(12'h100, 32'hFFFF_FFFF, "R11 wr");
        wr(A_DOOR, 32'hFFFF_FFFF, "R11 door wr");
        rd(12'h100, "R11 rd"); chk("R11 unmapped read zero", sw_rdata, 32'h0);
        rd(A_PEND, "R11 pend"); chk("R11 pending unchanged", sw_rdata, 32'h0000_0200);
        rd(A_ESET, "R11 mask"); chk("R11 mask unchanged", sw_rdata, 32'h0000_0020);

        // Random mix checked against the model every cycle
        for (int i = 0; i < 4000; i++) begin
            logic [11:0] a;
            logic [11:0] ma;
            logic [31:0] d;
            int sel;
            sel = $urandom % 5;
            a = (sel == 0) ? A_PEND : (sel == 1) ? A_ESET : (sel == 2) ? A_ECLR :
                (sel == 3) ? A_DOOR : 12'($urandom);
            ma = ($urandom % 4 != 0) ? A_DOOR : 12'($urandom);
            d = $urandom;
            if (a == A_PEND && ($urandom % 2 == 1)) d = ~(32'h1 << ($urandom % 32));
            tick($urandom % 3 == 0, $urandom % 2 == 0, a, d,
                 $urandom % 3 == 0, ma, $urandom, "random R2 R4 R5 R6");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule